// File: doc/BRIEF.md
# Single to half precision converter

This block narrows a 32-bit IEEE-754 binary32 operand to a 16-bit binary16 value. Finite values are rounded to nearest, with ties going to the even result. Values too small for a normal half-precision encoding become half-precision subnormals. Values too large saturate to a signed infinity. Zeros and infinities keep their sign. A NaN keeps as much of its payload as fits, and its quiet bit is forced on. A mode input can instead replace every NaN with one canonical quiet NaN.

Each accepted operand yields one result exactly one clock later, together with four exception flags. A pipeline or an execution unit can issue one conversion per cycle without stalls. Flush-to-zero and directed rounding are not provided.

Top module: `fp_narrow_s2h`

## Requirements
- R1: An input whose bits other than bit 31 are all zero produces 0x0000 (sign 0) or 0x8000 (sign 1), with all flags clear.
- R2: An input with biased exponent 255 and a zero fraction produces 0x7C00 (sign 0) or 0xFC00 (sign 1), with all flags clear.
- R3: With `dn_mode` low, a NaN input (exponent 255, nonzero fraction) produces its sign in bit 15, ones in bits 14:10, a one in bit 9 and input fraction bits 21:13 in bits 8:0.
- R4: With `dn_mode` high, every NaN input produces 0x7E00, whatever its sign or payload.
- R5: `flag_invalid` is set exactly when the input is a NaN whose quiet bit (bit 22) is clear, in either NaN mode. No other input sets it.
- R6: A finite input within normal half-precision range is rounded to 10 fraction bits, to nearest with ties to even. `flag_inexact` is set exactly when the discarded bits are not all zero.
- R7: When rounding carries out of the fraction, the exponent goes up by one and the fraction becomes zero. For example, 0x3FFFFFFF gives 0x4000.
- R8: A finite input whose rounded magnitude exceeds 65504 produces a signed infinity with `flag_overflow` and `flag_inexact` set. 65504 itself (0x477FE000) gives 0x7BFF with no flags.
- R9: A finite input below 2^-14 in magnitude is shifted into a subnormal result and rounded using a guard bit and a sticky bit. Binary32 subnormals therefore give a signed zero.
- R10: A value just below 2^-14 that rounds up gives the smallest normal encoding (0x0400 or 0x8400).
- R11: `flag_underflow` is set when the input magnitude is below 2^-14 before rounding and the result is inexact. An exact tiny result leaves it clear.
- R12: `out_valid` equals `in_valid` from the previous cycle. Result and flags are registered, with one cycle of latency. After reset `out_valid` is low, and `out_bits` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 32 | binary32 operand |
| dn_mode | input | 1 | 1: all NaNs become the canonical quiet NaN |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_bits | output | 16 | binary16 result |
| flag_invalid | output | 1 | Signalling NaN seen |
| flag_overflow | output | 1 | Result saturated to infinity |
| flag_underflow | output | 1 | Tiny and inexact |
| flag_inexact | output | 1 | Result differs from the input value |

## Verification
The bench builds the block with its default widths: an 8-bit exponent with a 23-bit fraction narrowed to a 5-bit exponent with a 10-bit fraction. With these widths every corner that matters is reachable. Ties sit exactly at fraction bit 12. The overflow boundary sits at 65520. Right-shift amounts run from zero up to the clamp, so results can move from normal to subnormal to zero. Binary32 subnormals reach the fully sticky case. Directed values pin each boundary. Random operands, concentrated near the half-precision exponent range, are checked against a real-arithmetic model.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Operand class that selects the result path.
    typedef enum logic [1:0] {
        K_FINITE = 2'd0,
        K_ZERO   = 2'd1,
        K_INF    = 2'd2,
        K_NAN    = 2'd3
    } kind_e;

    // Exception flags produced alongside each result.
    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    function automatic kind_e classify(input logic exp_zero,
                                       input logic exp_ones,
                                       input logic frac_zero);
        if (exp_ones) begin
            return frac_zero ? K_INF : K_NAN;
        end
        if (exp_zero && frac_zero) begin
            return K_ZERO;
        end
        return K_FINITE;
    endfunction

endpackage

// File: rtl/fpn_round.sv
module fpn_round
    import fpn_pkg::*;
#(
    parameter int SRC_EXP = 8,
    parameter int SRC_MAN = 23,
    parameter int DST_EXP = 5,
    parameter int DST_MAN = 10
) (
    input  logic                       sign,
    input  logic [SRC_EXP-1:0]         exp_b,
    input  logic [SRC_MAN-1:0]         frac,
    output logic [DST_EXP+DST_MAN:0]   res,
    output flags_t                     flags
);
    localparam int SW       = SRC_MAN + 1;                // significand width
    localparam int KW       = DST_MAN + 1;                // kept bits incl. leading
    localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
    localparam int DST_EMAX = (1 << DST_EXP) - 1;
    localparam int BASE     = SRC_MAN - DST_MAN;          // shift for normal results
    localparam int MAXR     = SW + 2;                     // total shift clamp
    localparam int SHMAX    = MAXR - BASE;                // extra subnormal shift clamp
    localparam int SHW      = $clog2(SHMAX + 1);
    localparam int WW       = MAXR + KW;

    logic [SW-1:0]  sig;
    int             h;          // destination biased exponent before rounding
    int             sh_full;
    logic [SHW-1:0] sh;
    logic [WW-1:0]  wide;
    logic [KW-1:0]  keep;
    logic           guard;
    logic           sticky;
    logic           tiny;
    logic           up;
    logic [KW:0]    sum;
    int             exp_n;
    logic           ovf;
    logic           inx;

    always_comb begin
        sig     = {|exp_b, frac};
        h       = ((exp_b == '0) ? 1 : int'(exp_b)) - SRC_BIAS + DST_BIAS;
        tiny    = (h < 1);
        sh_full = tiny ? (1 - h) : 0;
        sh      = (sh_full > SHMAX) ? SHW'(SHMAX) : SHW'(sh_full);
        wide    = {sig, {SHMAX{1'b0}}} >> sh;
        keep    = wide[MAXR +: KW];
        guard   = wide[MAXR-1];
        sticky  = |wide[MAXR-2:0];
        up      = guard & (sticky | keep[0]);
        sum     = {1'b0, keep} + (KW+1)'(up);
        inx     = guard | sticky;
        exp_n   = h + int'(sum[KW]);
        ovf     = !tiny && (exp_n >= DST_EMAX);

        if (ovf) begin
            res = {sign, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
        end else if (tiny) begin
            // carry into bit DST_MAN turns a subnormal into the smallest normal
            res = {sign, DST_EXP'(sum[DST_MAN]), sum[DST_MAN-1:0]};
        end else begin
            res = {sign, exp_n[DST_EXP-1:0], sum[DST_MAN-1:0]};
        end

        flags.invalid   = 1'b0;
        flags.overflow  = ovf;
        flags.underflow = tiny & inx;
        flags.inexact   = inx | ovf;
    end

endmodule

// File: rtl/fpn_special.sv
module fpn_special
    import fpn_pkg::*;
#(
    parameter int DST_EXP = 5,
    parameter int DST_MAN = 10
) (
    input  kind_e                      kind,
    input  logic                       sign,
    input  logic                       quiet,
    input  logic [DST_MAN-2:0]         payload,
    input  logic                       dn_mode,
    output logic [DST_EXP+DST_MAN:0]   res,
    output flags_t                     flags
);
    localparam logic [DST_EXP+DST_MAN:0] CANON_NAN =
        {1'b0, {DST_EXP{1'b1}}, 1'b1, {(DST_MAN-1){1'b0}}};

    always_comb begin
        flags = '0;
        unique case (kind)
            K_ZERO:  res = {sign, {(DST_EXP+DST_MAN){1'b0}}};
            K_INF:   res = {sign, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
            K_NAN: begin
                res           = dn_mode ? CANON_NAN
                                        : {sign, {DST_EXP{1'b1}}, 1'b1, payload};
                flags.invalid = !quiet;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fp_narrow_s2h.sv
module fp_narrow_s2h
    import fpn_pkg::*;
#(
    parameter int SRC_EXP = 8,
    parameter int SRC_MAN = 23,
    parameter int DST_EXP = 5,
    parameter int DST_MAN = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [SRC_EXP+SRC_MAN:0]           in_bits,
    input  logic                               dn_mode,
    output logic                               out_valid,
    output logic [DST_EXP+DST_MAN:0]           out_bits,
    output logic                               flag_invalid,
    output logic                               flag_overflow,
    output logic                               flag_underflow,
    output logic                               flag_inexact
);
    localparam int SW = SRC_EXP + SRC_MAN + 1;
    localparam int DW = DST_EXP + DST_MAN + 1;
    localparam logic [DW-1:0] CANON_NAN =
        {1'b0, {DST_EXP{1'b1}}, 1'b1, {(DST_MAN-1){1'b0}}};

    logic               sign;
    logic [SRC_EXP-1:0] exp_b;
    logic [SRC_MAN-1:0] frac;
    kind_e              kind;

    assign sign  = in_bits[SW-1];
    assign exp_b = in_bits[SRC_MAN +: SRC_EXP];
    assign frac  = in_bits[SRC_MAN-1:0];
    assign kind  = classify(exp_b == '0, &exp_b, frac == '0);

    logic [DW-1:0] fin_res, spc_res, res_n, res_q;
    flags_t        fin_flg, spc_flg, flg_n, flg_q;

    fpn_round #(
        .SRC_EXP (SRC_EXP),
        .SRC_MAN (SRC_MAN),
        .DST_EXP (DST_EXP),
        .DST_MAN (DST_MAN)
    ) u_round (
        .sign  (sign),
        .exp_b (exp_b),
        .frac  (frac),
        .res   (fin_res),
        .flags (fin_flg)
    );

    fpn_special #(
        .DST_EXP (DST_EXP),
        .DST_MAN (DST_MAN)
    ) u_special (
        .kind    (kind),
        .sign    (sign),
        .quiet   (frac[SRC_MAN-1]),
        .payload (frac[SRC_MAN-2 -: DST_MAN-1]),
        .dn_mode (dn_mode),
        .res     (spc_res),
        .flags   (spc_flg)
    );

    always_comb begin
        if (kind == K_FINITE) begin
            res_n = fin_res;
            flg_n = fin_flg;
        end else begin
            res_n = spc_res;
            flg_n = spc_flg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
            flg_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_n;
                flg_q <= flg_n;
            end
        end
    end

    assign out_bits       = res_q;
    assign flag_invalid   = flg_q.invalid;
    assign flag_overflow  = flg_q.overflow;
    assign flag_underflow = flg_q.underflow;
    assign flag_inexact   = flg_q.inexact;

    // R12: strobe follows the operand strobe by one cycle
    p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: signed zero in, signed zero out, quiet flags
    p_zero_pass_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_bits[SW-2:0] == '0)
        |=> (out_bits[DW-2:0] == '0) && (out_bits[DW-1] == $past(in_bits[SW-1]))
            && !flag_invalid && !flag_overflow && !flag_underflow && !flag_inexact);

    // R4: canonical NaN in default-NaN mode
    p_default_nan_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && dn_mode && (&in_bits[SRC_MAN +: SRC_EXP]) && (in_bits[SRC_MAN-1:0] != '0)
        |=> out_bits == CANON_NAN);

    // R5: an invalid result is always a quiet NaN encoding
    p_invalid_is_qnan_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_invalid
        |-> (&out_bits[DST_MAN +: DST_EXP]) && out_bits[DST_MAN-1] && !flag_inexact);

    // R8: overflow implies inexact and an infinity encoding
    p_no_overflow_finite_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_overflow
        |-> flag_inexact && (&out_bits[DST_MAN +: DST_EXP]) && (out_bits[DST_MAN-1:0] == '0));

    // R11: underflow only ever accompanies an inexact result
    p_underflow_inexact_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_underflow |-> flag_inexact && !flag_overflow);

endmodule

// File: tb/tb_fp_narrow_s2h.sv
`timescale 1ns/1ps
module tb_fp_narrow_s2h;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        dn_mode = 1'b0;
    logic        out_valid;
    logic [15:0] out_bits;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [19:0] exp_q[$];
    logic [31:0] in_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    fp_narrow_s2h dut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_bits        (in_bits),
        .dn_mode        (dn_mode),
        .out_valid      (out_valid),
        .out_bits       (out_bits),
        .flag_invalid   (flag_invalid),
        .flag_overflow  (flag_overflow),
        .flag_underflow (flag_underflow),
        .flag_inexact   (flag_inexact)
    );

    // Flag order in expected words: {invalid, overflow, underflow, inexact}
    function automatic logic [19:0] ref_model(input logic [31:0] x, input logic dn);
        logic        s;
        logic [7:0]  e;
        logic [22:0] f;
        real         a, p, q, fr;
        int          k;
        longint      n;
        logic [15:0] r;
        logic [3:0]  fl;
        s  = x[31];
        e  = x[30:23];
        f  = x[22:0];
        fl = 4'b0000;
        if (e == 8'hFF) begin
            if (f == 0) return {s, 5'h1F, 10'h000, 4'b0000};
            fl[3] = !f[22];
            r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, f[21:13]};
            return {r, fl};
        end
        if (e == 0 && f == 0) return {s, 15'h0000, 4'b0000};
        a = real'(int'({(e != 0), f}));
        k = ((e == 0) ? 1 : int'(e)) - 150;
        while (k > 0) begin a = a * 2.0; k--; end
        while (k < 0) begin a = a / 2.0; k++; end
        if (a >= 65536.0) return {s, 5'h1F, 10'h000, 4'b0101};
        p = 1.0 / 16384.0;
        k = -14;
        while (a >= 2.0 * p) begin p = p * 2.0; k++; end
        q  = a * 1024.0 / p;
        n  = longint'($floor(q));
        fr = q - real'(n);
        if (fr > 0.5 || (fr == 0.5 && n[0])) n++;
        if (fr != 0.0) fl[0] = 1'b1;
        if (a < 1.0 / 16384.0) begin
            fl[1] = fl[0];
            r = {s, 15'(n)};
        end else begin
            if (n == 2048) begin n = 1024; k++; end
            if (k + 15 >= 31) return {s, 5'h1F, 10'h000, 4'b0101};
            r = {s, 5'(k + 15), 10'(n - 1024)};
        end
        return {r, fl};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv,
                         input string what);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, expv);
        end
    endtask

    task automatic push(input logic [31:0] x, input logic dn, input logic [19:0] e,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = x;
        dn_mode  = dn;
        exp_q.push_back(e);
        in_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // directed: the literal expectation is also compared with the model
    task automatic send_known(input logic [31:0] x, input logic dn, input logic [15:0] r,
                              input logic [3:0] fl, input string tag);
        logic [19:0] m;
        m = ref_model(x, dn);
        check(tag, {12'h0, m}, {12'h0, r, fl}, "model");
        push(x, dn, {r, fl}, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    initial begin
        logic [19:0] e;
        logic [31:0] x;
        string       t;
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    x = in_q.pop_front();
                    t = tag_q.pop_front();
                    check("R12", {31'b0, out_valid}, 32'd1, "out_valid");
                    check(t, {16'h0, out_bits}, {16'h0, e[19:4]}, $sformatf("result in=%h", x));
                    check(t, {28'h0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
                          {28'h0, e[3:0]}, $sformatf("flags in=%h", x));
                end else if (out_valid) begin
                    check("R12", {31'b0, out_valid}, 32'd0, "unexpected out_valid");
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {31'b0, out_valid}, 32'd0, "reset out_valid");
        check("R12", {16'h0, out_bits}, 32'd0, "reset out_bits");
        check("R12", {28'h0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
              32'd0, "reset flags");
        rst = 1'b0;
        idle(2);

        // R1
        send_known(32'h0000_0000, 1'b0, 16'h0000, 4'b0000, "R1");
        send_known(32'h8000_0000, 1'b1, 16'h8000, 4'b0000, "R1");
        // R2
        send_known(32'h7F80_0000, 1'b0, 16'h7C00, 4'b0000, "R2");
        send_known(32'hFF80_0000, 1'b1, 16'hFC00, 4'b0000, "R2");
        // R3 / R5
        send_known(32'h7FC0_0000, 1'b0, 16'h7E00, 4'b0000, "R3");
        send_known(32'hFFC1_2345, 1'b0, 16'hFE09, 4'b0000, "R3");
        send_known(32'h7F81_2345, 1'b0, 16'h7E09, 4'b1000, "R5");
        // R4 / R5
        send_known(32'h7F81_2345, 1'b1, 16'h7E00, 4'b1000, "R4");
        send_known(32'hFFC0_0001, 1'b1, 16'h7E00, 4'b0000, "R4");
        idle(1);
        // R6
        send_known(32'h3F80_0000, 1'b0, 16'h3C00, 4'b0000, "R6");
        send_known(32'h3F80_1000, 1'b0, 16'h3C00, 4'b0001, "R6");
        send_known(32'h3F80_3000, 1'b0, 16'h3C02, 4'b0001, "R6");
        send_known(32'h3F80_1001, 1'b0, 16'h3C01, 4'b0001, "R6");
        // R7
        send_known(32'h3FFF_FFFF, 1'b0, 16'h4000, 4'b0001, "R7");
        // R8
        send_known(32'h477F_E000, 1'b0, 16'h7BFF, 4'b0000, "R8");
        send_known(32'h477F_EFFF, 1'b0, 16'h7BFF, 4'b0001, "R8");
        send_known(32'h477F_F000, 1'b0, 16'h7C00, 4'b0101, "R8");
        send_known(32'hC77F_F000, 1'b0, 16'hFC00, 4'b0101, "R8");
        send_known(32'h7F00_0000, 1'b0, 16'h7C00, 4'b0101, "R8");
        idle(2);
        // R9
        send_known(32'h3380_0000, 1'b0, 16'h0001, 4'b0000, "R9");
        send_known(32'h3880_0000, 1'b0, 16'h0400, 4'b0000, "R9");
        send_known(32'h3300_0000, 1'b0, 16'h0000, 4'b0011, "R9");
        send_known(32'h3300_0001, 1'b0, 16'h0001, 4'b0011, "R9");
        send_known(32'h0000_0001, 1'b0, 16'h0000, 4'b0011, "R9");
        send_known(32'h8040_0000, 1'b0, 16'h8000, 4'b0011, "R9");
        // R10
        send_known(32'h387F_FFFF, 1'b0, 16'h0400, 4'b0011, "R10");
        send_known(32'hB87F_E000, 1'b0, 16'h8400, 4'b0011, "R10");
        // R11
        send_known(32'h387F_C000, 1'b0, 16'h03FF, 4'b0000, "R11");
        idle(1);

        // random operands, biased toward the half-precision range
        for (int i = 0; i < 600; i++) begin
            logic [31:0] x;
            logic        dn;
            x  = $urandom;
            dn = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0) x[30:23] = 8'(95 + $urandom_range(0, 50));
            push(x, dn, ref_model(x, dn), "RND");
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(4);
        check("R12", exp_q.size(), 32'd0, "pending results at end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule